// File: doc/BRIEF.md
# Clock-Domain Register Access Bridge

This block carries one register read or write at a time from a bus-side clock domain into a peripheral register file that runs on its own, unrelated clock. The peripheral clock may be faster or slower than the bus clock. The bus side issues an access with a request that is taken while the bridge shows ready. It receives a one-cycle completion pulse, and a read returns its data at the same moment. On the peripheral side the bridge drives one-cycle write and read strobes with an address. The register file is expected to return read data one peripheral cycle after a read strobe.

The crossing works with toggle handshakes. A request toggle goes toward the peripheral and an acknowledge toggle comes back, and each passes through a two-flop synchronizer. Address, direction and write data are held in bus-side registers from acceptance until the access completes, so the peripheral side can sample them as quasi-static values. The stages are arranged so that every access costs a fixed count of edges in each domain. A write costs four bus edges plus two peripheral edges, and a read costs four bus edges plus four peripheral edges. Software can therefore walk a block of consecutive control registers with back-to-back accesses and know each one's cost.

Top module: `abr_bridge`

## Requirements
- R1: After a synchronous active-low reset of each domain, `bus_ready` is 1, `bus_done` is 0, `bus_rdata` is 0, and both peripheral strobes are 0.
- R2: An access is accepted on a bus rising edge where `bus_req` and `bus_ready` are both 1. From the next cycle `bus_ready` stays 0 until completion, so at most one access is outstanding.
- R3: For an accepted write (`bus_we`=1), `per_wr_en` is 0 after the first peripheral rising edge that follows acceptance. It is 1 for exactly the cycle after the second such edge, with `per_addr` and `per_wdata` equal to the accepted address and data.
- R4: A write completes on the third bus rising edge after the second peripheral rising edge that follows acceptance (4 bus plus 2 peripheral edges). Neither `bus_done` nor `bus_ready` is 1 before that edge.
- R5: For an accepted read, `per_rd_en` is 1 for exactly the cycle after the second peripheral rising edge that follows acceptance, with `per_addr` equal to the accepted address. `per_addr` holds through the next cycle. The bridge takes `per_rdata` on the fourth peripheral rising edge after acceptance.
- R6: A read completes on the third bus rising edge after that fourth peripheral edge (4 bus plus 4 peripheral edges). `bus_rdata` then carries the register value and holds it until a later read completes.
- R7: `bus_done` is a single-cycle pulse, and `bus_ready` is 1 in the same cycle.
- R8: Back-to-back accesses to consecutive addresses complete in issue order. Each produces exactly one peripheral strobe of its own kind, and the two strobes are never 1 together.
- R9: A request raised while `bus_ready` is 0 is ignored. It produces no strobe, and the register it names keeps its value.
- R10: The completion of a write leaves `bus_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_b | input | 1 | Bus-side clock |
| rst_b_n | input | 1 | Bus-side synchronous active-low reset |
| bus_req | input | 1 | Access request, taken when `bus_ready` is 1 |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_ready | output | 1 | Bridge idle and able to take a request |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_rdata | output | DW | Data of the last completed read |
| clk_p | input | 1 | Peripheral clock |
| rst_p_n | input | 1 | Peripheral-side synchronous active-low reset |
| per_wr_en | output | 1 | One-cycle write strobe to the register file |
| per_rd_en | output | 1 | One-cycle read strobe to the register file |
| per_addr | output | AW | Register address for either strobe |
| per_wdata | output | DW | Write data for the write strobe |
| per_rdata | input | DW | Register file read data, valid the cycle after `per_rd_en` |

## Verification
The bench runs the peripheral clock at four periods that have no integer ratio to the bus clock, some faster and some slower. For every access it counts the real clock edges in each domain and expects completion on exactly the computed bus edge. A bridge that waited an extra synchronizer stage, or finished a read on the write schedule, would complete one edge late or early. Consecutive-address writes followed by read-backs against a reference model catch a read that hands back stale capture data or a write that sampled the hold registers at the wrong time. Junk requests raised while the bridge is busy, and reads whose results must survive later writes, expose a bridge that accepts a second outstanding access or overwrites read data on a write completion.

// File: rtl/abr_pkg.sv
`timescale 1ns/1ps
// Shared state encodings for the clock-domain register bridge.
// Assumes: nothing beyond the two handshake FSMs uses these types.
package abr_pkg;

    // Bus-side handshake state.
    typedef enum logic {
        B_IDLE = 1'b0,
        B_WAIT = 1'b1
    } bus_state_t;

    // Peripheral-side handshake state.
    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_RWAIT = 2'd1,
        P_RCAP  = 2'd2
    } per_state_t;

endpackage

// File: rtl/abr_tog_sync.sv
`timescale 1ns/1ps
// Toggle synchronizer with edge detection.
// It moves a toggle signal into the local clock domain through STAGES flops
// and pulses edge_o for one cycle per toggle.
// EARLY=1: the edge comes from the last two synchronizer stages, so it is seen
//          one cycle sooner, and the first stage still gets a full cycle to resolve.
// EARLY=0: the edge comes from the last stage against a separate 'seen' flop.
// Assumes: tog_i changes at most once per handshake and is glitch-free.
module abr_tog_sync #(
    parameter int STAGES = 2,
    parameter bit EARLY  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    output logic edge_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] q;

    // Shift the asynchronous toggle through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= {q[LAST-1:0], tog_i};
    end

    generate
        if (EARLY) begin : g_early
            // Edge visible while the new value sits between the last two stages.
            assign edge_o = q[LAST-1] ^ q[LAST];
        end else begin : g_late
            logic seen_q;
            // Remember the last toggle value already acted upon.
            always_ff @(posedge clk) begin
                if (!rst_n) seen_q <= 1'b0;
                else        seen_q <= q[LAST];
            end
            assign edge_o = q[LAST] ^ seen_q;
        end
    endgenerate

endmodule

// File: rtl/abr_bus_side.sv
`timescale 1ns/1ps
// Bus-side handshake controller.
// It accepts one access, holds address, direction and data stable, flips the
// request toggle, then waits for the synchronized acknowledge edge. On that
// edge it pulses done and, for a read, registers the peripheral read data.
// Assumes: rdata_p is stable from the acknowledge toggle until the next read.
module abr_bus_side #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk_b,
    input  logic          rst_b_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          bus_ready,
    output logic          bus_done,
    output logic [DW-1:0] bus_rdata,
    input  logic          ack_edge,
    input  logic [DW-1:0] rdata_p,
    output logic          req_tgl,
    output logic          hold_we,
    output logic [AW-1:0] hold_addr,
    output logic [DW-1:0] hold_wdata
);
    import abr_pkg::*;

    bus_state_t state_q;
    logic       pend_rd_q;

    assign bus_ready = (state_q == B_IDLE);

    // Accept a request, hold its fields and wait for the returning acknowledge.
    always_ff @(posedge clk_b) begin
        if (!rst_b_n) begin
            state_q    <= B_IDLE;
            pend_rd_q  <= 1'b0;
            req_tgl    <= 1'b0;
            hold_we    <= 1'b0;
            hold_addr  <= '0;
            hold_wdata <= '0;
            bus_done   <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_done <= 1'b0;
            case (state_q)
                B_IDLE: begin
                    if (bus_req) begin
                        hold_we    <= bus_we;
                        hold_addr  <= bus_addr;
                        hold_wdata <= bus_wdata;
                        pend_rd_q  <= ~bus_we;
                        req_tgl    <= ~req_tgl;
                        state_q    <= B_WAIT;
                    end
                end
                B_WAIT: begin
                    if (ack_edge) begin
                        bus_done <= 1'b1;
                        if (pend_rd_q) bus_rdata <= rdata_p;
                        state_q  <= B_IDLE;
                    end
                end
                default: state_q <= B_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/abr_per_side.sv
`timescale 1ns/1ps
// Peripheral-side handshake controller.
// On the synchronized request edge it samples the bus-side hold registers
// and issues one write or read strobe. A write acknowledges at once. A read
// waits one cycle for the register file, captures its data, then acknowledges.
// Assumes: the register file returns per_rdata the cycle after per_rd_en, and
// the hold registers are stable from the request toggle until acknowledge.
module abr_per_side #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk_p,
    input  logic          rst_p_n,
    input  logic          req_edge,
    input  logic          hold_we,
    input  logic [AW-1:0] hold_addr,
    input  logic [DW-1:0] hold_wdata,
    input  logic [DW-1:0] per_rdata,
    output logic          per_wr_en,
    output logic          per_rd_en,
    output logic [AW-1:0] per_addr,
    output logic [DW-1:0] per_wdata,
    output logic          ack_tgl,
    output logic [DW-1:0] rdata_p
);
    import abr_pkg::*;

    per_state_t state_q;

    // Launch strobes, capture read data and flip the acknowledge toggle.
    always_ff @(posedge clk_p) begin
        if (!rst_p_n) begin
            state_q   <= P_IDLE;
            per_wr_en <= 1'b0;
            per_rd_en <= 1'b0;
            per_addr  <= '0;
            per_wdata <= '0;
            ack_tgl   <= 1'b0;
            rdata_p   <= '0;
        end else begin
            per_wr_en <= 1'b0;
            per_rd_en <= 1'b0;
            case (state_q)
                P_IDLE: begin
                    if (req_edge) begin
                        per_addr <= hold_addr;
                        if (hold_we) begin
                            per_wr_en <= 1'b1;
                            per_wdata <= hold_wdata;
                            ack_tgl   <= ~ack_tgl;
                        end else begin
                            per_rd_en <= 1'b1;
                            state_q   <= P_RWAIT;
                        end
                    end
                end
                P_RWAIT: state_q <= P_RCAP;
                P_RCAP: begin
                    rdata_p <= per_rdata;
                    ack_tgl <= ~ack_tgl;
                    state_q <= P_IDLE;
                end
                default: state_q <= P_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/abr_bridge.sv
`timescale 1ns/1ps
// Clock-domain register access bridge (top).
// It joins the bus-side and peripheral-side controllers through two toggle
// synchronizers. The request path uses the early edge form so a write
// acknowledges on the second peripheral edge. The acknowledge path uses the
// late form so the bus side spends four edges per access.
// Assumes: clk_b and clk_p are unrelated; each domain has its own reset, and
// both resets are applied together.
module abr_bridge #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk_b,
    input  logic          rst_b_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          bus_ready,
    output logic          bus_done,
    output logic [DW-1:0] bus_rdata,
    input  logic          clk_p,
    input  logic          rst_p_n,
    output logic          per_wr_en,
    output logic          per_rd_en,
    output logic [AW-1:0] per_addr,
    output logic [DW-1:0] per_wdata,
    input  logic [DW-1:0] per_rdata
);
    localparam int SYNC_STAGES = 2;

    logic          req_tgl;
    logic          ack_tgl;
    logic          req_edge;
    logic          ack_edge;
    logic          hold_we;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_wdata;
    logic [DW-1:0] rdata_p;

    abr_bus_side #(.AW(AW), .DW(DW)) u_bus (
        .clk_b      (clk_b),
        .rst_b_n    (rst_b_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_ready  (bus_ready),
        .bus_done   (bus_done),
        .bus_rdata  (bus_rdata),
        .ack_edge   (ack_edge),
        .rdata_p    (rdata_p),
        .req_tgl    (req_tgl),
        .hold_we    (hold_we),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata)
    );

    abr_tog_sync #(.STAGES(SYNC_STAGES), .EARLY(1'b1)) u_req_sync (
        .clk    (clk_p),
        .rst_n  (rst_p_n),
        .tog_i  (req_tgl),
        .edge_o (req_edge)
    );

    abr_per_side #(.AW(AW), .DW(DW)) u_per (
        .clk_p      (clk_p),
        .rst_p_n    (rst_p_n),
        .req_edge   (req_edge),
        .hold_we    (hold_we),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata),
        .per_rdata  (per_rdata),
        .per_wr_en  (per_wr_en),
        .per_rd_en  (per_rd_en),
        .per_addr   (per_addr),
        .per_wdata  (per_wdata),
        .ack_tgl    (ack_tgl),
        .rdata_p    (rdata_p)
    );

    abr_tog_sync #(.STAGES(SYNC_STAGES), .EARLY(1'b0)) u_ack_sync (
        .clk    (clk_b),
        .rst_n  (rst_b_n),
        .tog_i  (ack_tgl),
        .edge_o (ack_edge)
    );

endmodule

// File: rtl/abr_bridge_chk.sv
`timescale 1ns/1ps
// Protocol checker for abr_bridge, bound to every instance of it.
// Assumes: it is attached by the bind statement at the end of this file.
module abr_bridge_chk #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input logic          clk_b,
    input logic          rst_b_n,
    input logic          bus_req,
    input logic          bus_ready,
    input logic          bus_done,
    input logic [DW-1:0] bus_rdata,
    input logic          clk_p,
    input logic          rst_p_n,
    input logic          per_wr_en,
    input logic          per_rd_en,
    input logic [AW-1:0] per_addr
);
    p_accept_busy_r2: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (bus_req && bus_ready) |=> !bus_ready);

    p_done_single_r7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        bus_done |=> !bus_done);

    p_done_ready_r7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        bus_done |-> bus_ready);

    // Read data only moves at a completion (R6, R10).
    p_rdata_hold_r6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        !bus_done |=> ($stable(bus_rdata) || bus_done));

    p_wr_single_r3: assert property (@(posedge clk_p) disable iff (!rst_p_n)
        per_wr_en |=> !per_wr_en);

    p_rd_single_r5: assert property (@(posedge clk_p) disable iff (!rst_p_n)
        per_rd_en |=> (!per_rd_en && $stable(per_addr)));

    p_one_strobe_r8: assert property (@(posedge clk_p) disable iff (!rst_p_n)
        !(per_wr_en && per_rd_en));

endmodule

bind abr_bridge abr_bridge_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk_b     (clk_b),
    .rst_b_n   (rst_b_n),
    .bus_req   (bus_req),
    .bus_ready (bus_ready),
    .bus_done  (bus_done),
    .bus_rdata (bus_rdata),
    .clk_p     (clk_p),
    .rst_p_n   (rst_p_n),
    .per_wr_en (per_wr_en),
    .per_rd_en (per_rd_en),
    .per_addr  (per_addr)
);

// File: tb/tb_abr_bridge.sv
`timescale 1ns/1ps
module tb_abr_bridge;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int NV = 16;

    // Vector: {write, period index, address, data}
    localparam logic [42:0] VEC [NV] = '{
        {1'b1, 2'd0, 8'h10, 32'h1111_0001},
        {1'b1, 2'd0, 8'h11, 32'h2222_0002},
        {1'b1, 2'd0, 8'h12, 32'h3333_0003},
        {1'b0, 2'd0, 8'h10, 32'h0},
        {1'b0, 2'd0, 8'h11, 32'h0},
        {1'b0, 2'd0, 8'h12, 32'h0},
        {1'b1, 2'd1, 8'h20, 32'hCAFE_0020},
        {1'b1, 2'd1, 8'h21, 32'hBEEF_0021},
        {1'b0, 2'd1, 8'h20, 32'h0},
        {1'b0, 2'd1, 8'h21, 32'h0},
        {1'b1, 2'd2, 8'h30, 32'h0000_F00D},
        {1'b0, 2'd2, 8'h30, 32'h0},
        {1'b0, 2'd2, 8'h31, 32'h0},
        {1'b1, 2'd3, 8'h40, 32'hDEAD_0040},
        {1'b0, 2'd3, 8'h40, 32'h0},
        {1'b0, 2'd3, 8'h12, 32'h0}
    };

    logic          clk_b = 1'b0;
    logic          clk_p = 1'b0;
    logic          rst_b_n = 1'b0;
    logic          rst_p_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_ready;
    logic          bus_done;
    logic [DW-1:0] bus_rdata;
    logic          per_wr_en;
    logic          per_rd_en;
    logic [AW-1:0] per_addr;
    logic [DW-1:0] per_wdata;
    logic [DW-1:0] per_rdata;

    real tp = 13.2;
    int  total = 0;
    int  bad = 0;
    int  nwr = 0;
    int  nrd = 0;
    logic [DW-1:0] regs [256];
    logic [DW-1:0] shadow [256];

    abr_bridge #(.AW(AW), .DW(DW)) dut (
        .clk_b(clk_b), .rst_b_n(rst_b_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_done(bus_done), .bus_rdata(bus_rdata), .clk_p(clk_p),
        .rst_p_n(rst_p_n), .per_wr_en(per_wr_en), .per_rd_en(per_rd_en),
        .per_addr(per_addr), .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    // 50 MHz bus clock; peripheral edges always land on x.x7 ns, never on a bus edge.
    always #10 clk_b = ~clk_b;
    initial begin
        #0.07;
        forever #(tp / 2.0) clk_p = ~clk_p;
    end

    function automatic real period_of(input logic [1:0] i);
        case (i)
            2'd0: return 13.2;
            2'd1: return 29.4;
            2'd2: return 7.6;
            default: return 41.8;
        endcase
    endfunction

    // Peripheral register file stub: one-cycle read.
    always @(posedge clk_p) begin
        if (!rst_p_n) begin
            for (int i = 0; i < 256; i++) regs[i] <= 32'hA500_0000 | i;
            per_rdata <= '0;
        end else begin
            if (per_wr_en) regs[per_addr] <= per_wdata;
            if (per_rd_en) per_rdata <= regs[per_addr];
        end
    end

    // Count strobes mid-cycle.
    always @(negedge clk_p) begin
        if (per_wr_en) nwr++;
        if (per_rd_en) nrd++;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_access(input logic we, input logic [7:0] a, input logic [31:0] d, input bit junk);
        logic [31:0] prev_rd;
        int w0;
        int r0;
        prev_rd = bus_rdata;
        w0 = nwr;
        r0 = nrd;
        @(negedge clk_b);
        chk(bus_ready == 1'b1, "R2 ready before issue", bus_ready, 1);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk_b);
        fork
            begin
                @(negedge clk_b);
                if (junk) begin
                    bus_we = 1'b1; bus_addr = a ^ 8'h01; bus_wdata = 32'h0BAD_0BAD;
                    repeat (2) @(negedge clk_b);
                end
                bus_req = 1'b0;
            end
            begin
                @(posedge clk_p); #0.5;
                chk(!per_wr_en && !per_rd_en, "R3 R5 no strobe after first edge", {per_wr_en, per_rd_en}, 0);
                @(posedge clk_p); #0.5;
                if (we) begin
                    chk(per_wr_en && !per_rd_en, "R3 write strobe", {per_wr_en, per_rd_en}, 2);
                    chk(per_addr == a, "R3 write address", per_addr, a);
                    chk(per_wdata == d, "R3 write data", per_wdata, d);
                end else begin
                    chk(per_rd_en && !per_wr_en, "R5 read strobe", {per_wr_en, per_rd_en}, 1);
                    chk(per_addr == a, "R5 read address", per_addr, a);
                end
            end
            begin
                if (we) repeat (2) @(posedge clk_p);
                else    repeat (4) @(posedge clk_p);
                repeat (2) @(posedge clk_b); #1;
                chk(!bus_ready && !bus_done, "R2 R4 R6 busy until completion edge", {bus_ready, bus_done}, 0);
                @(posedge clk_b); #1;
                chk(bus_done, we ? "R4 write completion edge" : "R6 read completion edge", bus_done, 1);
                chk(bus_ready, "R7 ready with done", bus_ready, 1);
                if (we) chk(bus_rdata == prev_rd, "R10 rdata kept on write", bus_rdata, prev_rd);
                else    chk(bus_rdata == shadow[a], "R6 read data", bus_rdata, shadow[a]);
                @(posedge clk_b); #1;
                chk(!bus_done, "R7 done single pulse", bus_done, 0);
            end
        join
        if (we) shadow[a] = d;
        chk((nwr - w0) == (we ? 1 : 0) && (nrd - r0) == (we ? 0 : 1),
            junk ? "R9 busy request ignored" : "R8 one strobe per access",
            {32'(nwr - w0), 32'(nrd - r0)}, we ? 64'h1_0000_0000 : 64'h1);
    endtask

    task automatic do_reset();
        rst_b_n = 1'b0; rst_p_n = 1'b0;
        repeat (5) @(posedge clk_b);
        repeat (5) @(posedge clk_p);
        @(negedge clk_b); rst_b_n = 1'b1; rst_p_n = 1'b1;
        #1;
        chk(bus_ready && !bus_done, "R1 bus idle after reset", {bus_ready, bus_done}, 2);
        chk(bus_rdata == '0, "R1 rdata cleared", bus_rdata, 0);
        chk(!per_wr_en && !per_rd_en, "R1 strobes low after reset", {per_wr_en, per_rd_en}, 0);
        for (int i = 0; i < 256; i++) shadow[i] = 32'hA500_0000 | i;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // Table walk: back-to-back consecutive-address accesses (R3-R8).
        for (int v = 0; v < NV; v++) begin
            tp = period_of(VEC[v][41:40]);
            do_access(VEC[v][42], VEC[v][39:32], VEC[v][31:0], 1'b0);
        end
        // R9: junk request held while busy must not become a second access.
        tp = 13.2;
        do_access(1'b1, 8'h50, 32'h5050_5050, 1'b1);
        do_access(1'b0, 8'h51, 32'h0, 1'b0);
        do_access(1'b0, 8'h50, 32'h0, 1'b0);
        // R10: a slow-clock write after a read keeps the read result.
        tp = 41.8;
        do_access(1'b1, 8'h60, 32'h6666_6060, 1'b0);
        tp = 7.6;
        do_access(1'b0, 8'h60, 32'h0, 1'b0);
        // R1: reset while idle returns everything to the initial state.
        do_reset();
        do_access(1'b0, 8'h10, 32'h0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule